// File: doc/BRIEF.md
# Bounded Inline Jump-Table Call Unit

This block executes a bounded table call on behalf of an instruction sequencer. The sequencer hands it the instruction pointer where an inline table begins, an 8-bit selector, an 8-bit upper bound and the current stack pointer, then pulses a start strobe. Each table entry is a 24-bit code address stored as three consecutive bytes, low byte first, directly after the instruction. When the selector does not exceed the bound, the unit fetches the chosen entry through a byte-wide read port. In the same window it writes the return point (the first byte past the table) onto the stack through a byte-wide push port. It then commits the new instruction pointer and stack pointer together.

When the selector exceeds the bound, the unit makes no call. It commits the return point as the next instruction pointer and raises the overflow and error flags. Software can test those flags after the dispatch and recover. The flag port carries only those two bits, so every other flag kept by the CPU is left alone. All address arithmetic is done modulo 2^24.

Top module: `jtab_dispatch`

## Requirements
- R1: While reset is held and in the first cycle after it is released, done_o, ip_we_o, sp_we_o, flag_we_o, rd_req_o and push_we_o are all low.
- R2: If sel_i <= lim_i, the unit issues exactly three reads, in the order slot, slot+1, slot+2, with slot = (ip_i + 3*sel_i) mod 2^24. The byte read at slot+k becomes bits [8k+7:8k] of the new ip_o.
- R3: If sel_i <= lim_i, the return point ret = (ip_i + 3*lim_i + 3) mod 2^24 is pushed as exactly three byte writes: ret[23:16] to sp_i-1, ret[15:8] to sp_i-2 and ret[7:0] to sp_i-3, in that order. At completion, sp_we_o=1 and sp_o = sp_i-3, all modulo 2^24.
- R4: An in-range dispatch completes with flag_we_o=1, flag_v_o=0, flag_er_o=0 and ip_we_o=1.
- R5: If sel_i > lim_i, the unit issues no read and no push. It completes with ip_we_o=1, ip_o=ret, flag_we_o=1, flag_v_o=1, flag_er_o=1 and sp_we_o=0.
- R6: Let cycle 1 be the cycle after the clock edge that samples start_i. done_o rises in cycle 6 for an in-range dispatch and in cycle 1 for an out-of-range one.
- R7: Slot, read, return and stack addresses all wrap modulo 2^24 without carrying into any other bit.
- R8: done_o is a one-cycle pulse. ip_we_o, sp_we_o and flag_we_o are asserted only together with done_o.
- R9: The bound is inclusive. sel_i = lim_i calls, sel_i = lim_i+1 falls through, a bound of 0 calls only for selector 0, and a bound of 255 accepts every selector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a dispatch; sampled only when idle |
| ip_i | input | 24 | Address of the first table entry |
| sel_i | input | 8 | Table index |
| lim_i | input | 8 | Highest valid index |
| sp_i | input | 24 | Stack pointer before the call |
| rd_req_o | output | 1 | Byte read request |
| rd_addr_o | output | 24 | Byte read address |
| rd_data_i | input | 8 | Read data, valid the cycle after the request |
| push_we_o | output | 1 | Stack byte write strobe |
| push_addr_o | output | 24 | Stack byte write address |
| push_data_o | output | 8 | Stack byte write data |
| ip_we_o | output | 1 | Commit ip_o |
| ip_o | output | 24 | Next instruction pointer |
| sp_we_o | output | 1 | Commit sp_o |
| sp_o | output | 24 | Stack pointer after the push |
| flag_we_o | output | 1 | Commit the two flag bits |
| flag_v_o | output | 1 | Overflow flag value |
| flag_er_o | output | 1 | Error flag value |
| done_o | output | 1 | Completion pulse |

## Verification
The checks assume that the memory behind the read port always answers exactly one cycle after each request, and that start_i is raised only while no dispatch is in flight. They also assume that the stack port accepts a byte every cycle without stalling. The bench models memory with a registered lookup that follows that one-cycle rule. It raises start_i for a single cycle and always waits for done_o, plus one idle cycle, before the next start.

// File: rtl/jtab_pkg.sv
package jtab_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned ENTRY_BYTES = 3;
  localparam int unsigned SEL_W       = 8;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CALL = 2'd2,
    ST_FALL = 2'd3
  } jt_state_e;
endpackage

// File: rtl/jtab_addr_calc.sv
module jtab_addr_calc #(
  parameter int unsigned ADDR_W      = 24,
  parameter int unsigned SEL_W       = 8,
  parameter int unsigned ENTRY_BYTES = 3
) (
  input  logic [ADDR_W-1:0] ip_i,
  input  logic [SEL_W-1:0]  sel_i,
  input  logic [SEL_W-1:0]  lim_i,
  output logic [ADDR_W-1:0] slot_o,
  output logic [ADDR_W-1:0] ret_o,
  output logic              in_range_o
);
  localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(ENTRY_BYTES);

  logic [ADDR_W-1:0] sel_off, lim_off;

  // widths held at ADDR_W so all sums wrap
  assign sel_off    = ADDR_W'(sel_i) * STRIDE;
  assign lim_off    = ADDR_W'(lim_i) * STRIDE;
  assign slot_o     = ip_i + sel_off;
  assign ret_o      = ip_i + lim_off + STRIDE;
  assign in_range_o = (sel_i <= lim_i);
endmodule

// File: rtl/jtab_fetch.sv
module jtab_fetch #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [ADDR_W-1:0]        base_i,
  output logic                     rd_req_o,
  output logic [ADDR_W-1:0]        rd_addr_o,
  input  logic [BYTE_W-1:0]        rd_data_i,
  output logic                     done_o,
  output logic [NBYTES*BYTE_W-1:0] word_o
);
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic              active_q, pend_q, done_q;
  logic [CNT_W-1:0]  issue_q, pend_idx_q;
  logic [ADDR_W-1:0] base_q;

  assign rd_req_o  = active_q;
  assign rd_addr_o = base_q + ADDR_W'(issue_q);
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q   <= 1'b0;
      pend_q     <= 1'b0;
      done_q     <= 1'b0;
      issue_q    <= '0;
      pend_idx_q <= '0;
      base_q     <= '0;
    end else begin
      done_q     <= pend_q && (pend_idx_q == LAST);
      pend_q     <= active_q;
      pend_idx_q <= issue_q;
      if (go_i) begin
        active_q <= 1'b1;
        issue_q  <= '0;
        base_q   <= base_i;
      end else if (active_q) begin
        if (issue_q == LAST) begin
          active_q <= 1'b0;
          issue_q  <= '0;
        end else begin
          issue_q <= issue_q + 1'b1;
        end
      end
    end
  end

  // one capture lane per byte of the entry
  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [BYTE_W-1:0] byte_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                    byte_q <= '0;
      else if (pend_q && (pend_idx_q == CNT_W'(b)))   byte_q <= rd_data_i;
    end
    assign word_o[b*BYTE_W +: BYTE_W] = byte_q;
  end
endmodule

// File: rtl/jtab_push.sv
module jtab_push #(
  parameter int unsigned ADDR_W = 24,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned NBYTES = 3
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     go_i,
  input  logic [ADDR_W-1:0]        sp_i,
  input  logic [NBYTES*BYTE_W-1:0] data_i,
  output logic                     push_we_o,
  output logic [ADDR_W-1:0]        push_addr_o,
  output logic [BYTE_W-1:0]        push_data_o,
  output logic                     done_o,
  output logic [ADDR_W-1:0]        sp_new_o
);
  localparam int unsigned CNT_W = $clog2(NBYTES + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(NBYTES - 1);

  logic                     active_q, done_q;
  logic [CNT_W-1:0]         cnt_q;
  logic [ADDR_W-1:0]        sp_q;
  logic [NBYTES*BYTE_W-1:0] data_q;
  logic [BYTE_W-1:0]        lane [NBYTES];

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    assign lane[b] = data_q[b*BYTE_W +: BYTE_W];
  end

  // most significant byte lands at the highest address
  assign push_we_o   = active_q;
  assign push_addr_o = sp_q - ADDR_W'(cnt_q) - ADDR_W'(1);
  assign push_data_o = lane[LAST - cnt_q];
  assign done_o      = done_q;
  assign sp_new_o    = sp_q - ADDR_W'(NBYTES);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      done_q   <= 1'b0;
      cnt_q    <= '0;
      sp_q     <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i) begin
        active_q <= 1'b1;
        cnt_q    <= '0;
        sp_q     <= sp_i;
        data_q   <= data_i;
      end else if (active_q) begin
        if (cnt_q == LAST) begin
          active_q <= 1'b0;
          cnt_q    <= '0;
          done_q   <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/jtab_dispatch.sv
module jtab_dispatch
  import jtab_pkg::*;
#(
  parameter int unsigned BW = BYTE_W,
  parameter int unsigned EB = ENTRY_BYTES,
  parameter int unsigned SW = SEL_W,
  localparam int unsigned AW = EB * BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] ip_i,
  input  logic [SW-1:0] sel_i,
  input  logic [SW-1:0] lim_i,
  input  logic [AW-1:0] sp_i,
  output logic          rd_req_o,
  output logic [AW-1:0] rd_addr_o,
  input  logic [BW-1:0] rd_data_i,
  output logic          push_we_o,
  output logic [AW-1:0] push_addr_o,
  output logic [BW-1:0] push_data_o,
  output logic          ip_we_o,
  output logic [AW-1:0] ip_o,
  output logic          sp_we_o,
  output logic [AW-1:0] sp_o,
  output logic          flag_we_o,
  output logic          flag_v_o,
  output logic          flag_er_o,
  output logic          done_o
);
  jt_state_e     state_q;
  logic [AW-1:0] slot, ret, ret_q, target, sp_new;
  logic          in_range, launch;
  logic          fetch_done, push_done, fetch_seen_q, push_seen_q;
  logic          fetch_ok, push_ok;

  jtab_addr_calc #(.ADDR_W(AW), .SEL_W(SW), .ENTRY_BYTES(EB)) u_calc (
    .ip_i      (ip_i),
    .sel_i     (sel_i),
    .lim_i     (lim_i),
    .slot_o    (slot),
    .ret_o     (ret),
    .in_range_o(in_range)
  );

  assign launch = (state_q == ST_IDLE) && start_i && in_range;

  jtab_fetch #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(EB)) u_fetch (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .go_i     (launch),
    .base_i   (slot),
    .rd_req_o (rd_req_o),
    .rd_addr_o(rd_addr_o),
    .rd_data_i(rd_data_i),
    .done_o   (fetch_done),
    .word_o   (target)
  );

  jtab_push #(.ADDR_W(AW), .BYTE_W(BW), .NBYTES(EB)) u_push (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .go_i       (launch),
    .sp_i       (sp_i),
    .data_i     (ret),
    .push_we_o  (push_we_o),
    .push_addr_o(push_addr_o),
    .push_data_o(push_data_o),
    .done_o     (push_done),
    .sp_new_o   (sp_new)
  );

  assign fetch_ok = fetch_done || fetch_seen_q;
  assign push_ok  = push_done  || push_seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q      <= ST_IDLE;
      ret_q        <= '0;
      fetch_seen_q <= 1'b0;
      push_seen_q  <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          fetch_seen_q <= 1'b0;
          push_seen_q  <= 1'b0;
          if (start_i) begin
            ret_q   <= ret;
            state_q <= in_range ? ST_WAIT : ST_FALL;
          end
        end
        ST_WAIT: begin
          fetch_seen_q <= fetch_ok;
          push_seen_q  <= push_ok;
          if (fetch_ok && push_ok) state_q <= ST_CALL;
        end
        ST_CALL: state_q <= ST_IDLE;
        ST_FALL: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    done_o    = 1'b0;
    ip_we_o   = 1'b0;
    sp_we_o   = 1'b0;
    flag_we_o = 1'b0;
    flag_v_o  = 1'b0;
    flag_er_o = 1'b0;
    ip_o      = ret_q;
    sp_o      = sp_new;
    if (state_q == ST_CALL) begin
      done_o    = 1'b1;
      ip_we_o   = 1'b1;
      sp_we_o   = 1'b1;
      flag_we_o = 1'b1;
      ip_o      = target;
    end else if (state_q == ST_FALL) begin
      done_o    = 1'b1;
      ip_we_o   = 1'b1;
      flag_we_o = 1'b1;
      flag_v_o  = 1'b1;
      flag_er_o = 1'b1;
    end
  end
endmodule

// File: rtl/jtab_dispatch_chk.sv
module jtab_dispatch_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        rd_req_o,
  input logic [23:0] rd_addr_o,
  input logic        push_we_o,
  input logic [23:0] push_addr_o,
  input logic        ip_we_o,
  input logic        sp_we_o,
  input logic [23:0] sp_o,
  input logic        flag_we_o,
  input logic        flag_v_o,
  input logic        flag_er_o,
  input logic        done_o
);
  p_done_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_we_gated_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ip_we_o || sp_we_o || flag_we_o) |-> done_o);

  p_call_flags_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (flag_we_o && !flag_v_o && !flag_er_o));

  p_fall_flags_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !sp_we_o) |-> (flag_v_o && flag_er_o));

  p_rd_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req_o && $past(rd_req_o)) |-> (rd_addr_o == 24'($past(rd_addr_o) + 24'd1)));

  p_push_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_we_o && $past(push_we_o)) |-> (push_addr_o == 24'($past(push_addr_o) - 24'd1)));

  p_sp_final_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sp_we_o |-> (sp_o == $past(push_addr_o, 3)));

  p_quiet_done_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!rd_req_o && !push_we_o));
endmodule

bind jtab_dispatch jtab_dispatch_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .rd_req_o   (rd_req_o),
  .rd_addr_o  (rd_addr_o),
  .push_we_o  (push_we_o),
  .push_addr_o(push_addr_o),
  .ip_we_o    (ip_we_o),
  .sp_we_o    (sp_we_o),
  .sp_o       (sp_o),
  .flag_we_o  (flag_we_o),
  .flag_v_o   (flag_v_o),
  .flag_er_o  (flag_er_o),
  .done_o     (done_o)
);

// File: tb/jtab_dispatch_test.sv
`timescale 1ns/1ps
module jtab_dispatch_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [23:0] ip_i = '0, sp_i = '0;
  logic [7:0]  sel_i = '0, lim_i = '0;
  logic        rd_req_o, push_we_o, ip_we_o, sp_we_o, flag_we_o, flag_v_o, flag_er_o, done_o;
  logic [23:0] rd_addr_o, push_addr_o, ip_o, sp_o;
  logic [7:0]  rd_data_i = '0, push_data_o;

  int errors = 0;
  int checks = 0;

  always #2.5 clk_i = ~clk_i;

  jtab_dispatch uut (.*);

  function automatic logic [7:0] mem_byte(input logic [23:0] a);
    return 8'((a * 24'd37) ^ (a >> 9) ^ 24'h5a);
  endfunction

  logic [23:0] rd_log [8];
  int          rd_n;
  logic [23:0] pa_log [8];
  logic [7:0]  pd_log [8];
  int          push_n;

  always @(posedge clk_i) begin
    if (rd_req_o) begin
      rd_data_i <= mem_byte(rd_addr_o);
      if (rd_n < 8) rd_log[rd_n] = rd_addr_o;
      rd_n = rd_n + 1;
    end
    if (push_we_o) begin
      if (push_n < 8) begin
        pa_log[push_n] = push_addr_o;
        pd_log[push_n] = push_data_o;
      end
      push_n = push_n + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run_case(input logic [23:0] ip, input logic [7:0] sel,
                          input logic [7:0] lim, input logic [23:0] sp, input string tag);
    logic [23:0] slot, ret, tgt;
    bit          inr;
    int          cyc;
    slot = ip + 24'(sel) * 24'd3;
    ret  = ip + 24'(lim) * 24'd3 + 24'd3;
    inr  = (sel <= lim);
    tgt  = {mem_byte(slot + 24'd2), mem_byte(slot + 24'd1), mem_byte(slot)};
    rd_n = 0;
    push_n = 0;
    @(negedge clk_i);
    ip_i = ip; sel_i = sel; lim_i = lim; sp_i = sp; start_i = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    cyc = 1;
    while (!done_o && cyc < 40) begin
      @(negedge clk_i);
      cyc++;
    end
    chk(cyc == (inr ? 6 : 1), {tag, " R6 latency"}, cyc, inr ? 6 : 1);
    chk(ip_we_o && flag_we_o, {tag, " R8 commit strobes"}, {ip_we_o, flag_we_o}, 2'b11);
    if (inr) begin
      chk(ip_o == tgt, {tag, " R2 target"}, ip_o, tgt);
      chk(!flag_v_o && !flag_er_o, {tag, " R4 flags clear"}, {flag_v_o, flag_er_o}, 0);
      chk(sp_we_o && sp_o == 24'(sp - 24'd3), {tag, " R3 sp"}, sp_o, 24'(sp - 24'd3));
      chk(rd_n == 3, {tag, " R2 read count"}, rd_n, 3);
      for (int k = 0; k < 3; k++)
        chk(rd_log[k] == 24'(slot + 24'(k)), {tag, " R7 read addr"}, rd_log[k], 24'(slot + 24'(k)));
      chk(push_n == 3, {tag, " R3 push count"}, push_n, 3);
      for (int k = 0; k < 3; k++) begin
        chk(pa_log[k] == 24'(sp - 24'(k) - 24'd1), {tag, " R3 push addr"}, pa_log[k],
            24'(sp - 24'(k) - 24'd1));
        chk(pd_log[k] == ret[8*(2-k) +: 8], {tag, " R3 push data"}, pd_log[k], ret[8*(2-k) +: 8]);
      end
    end else begin
      chk(ip_o == ret, {tag, " R5 fallthrough ip"}, ip_o, ret);
      chk(flag_v_o && flag_er_o, {tag, " R5 flags set"}, {flag_v_o, flag_er_o}, 2'b11);
      chk(!sp_we_o, {tag, " R5 no sp write"}, sp_we_o, 0);
      chk(rd_n == 0 && push_n == 0, {tag, " R5 no bus traffic"}, rd_n + push_n, 0);
    end
    @(negedge clk_i);
    chk(!done_o && !ip_we_o && !sp_we_o, {tag, " R8 single pulse"}, {done_o, ip_we_o, sp_we_o}, 0);
  endtask

  task automatic t_reset();
    chk(!done_o && !ip_we_o && !sp_we_o && !flag_we_o && !rd_req_o && !push_we_o,
        "R1 in reset", {done_o, ip_we_o, sp_we_o, flag_we_o, rd_req_o, push_we_o}, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!done_o && !ip_we_o && !sp_we_o && !flag_we_o && !rd_req_o && !push_we_o,
        "R1 after release", {done_o, ip_we_o, sp_we_o, flag_we_o, rd_req_o, push_we_o}, 0);
  endtask

  task automatic t_basic();
    run_case(24'h001000, 8'd2, 8'd5, 24'h00f000, "R2 basic");
    run_case(24'h123456, 8'd0, 8'd9, 24'h0a0a0a, "R4 first");
  endtask

  task automatic t_bounds();
    run_case(24'h004000, 8'd7, 8'd7, 24'h008000, "R9 sel=lim");
    run_case(24'h004000, 8'd8, 8'd7, 24'h008000, "R9 sel=lim+1");
    run_case(24'h002200, 8'd0, 8'd0, 24'h003000, "R9 single hit");
    run_case(24'h002200, 8'd1, 8'd0, 24'h003000, "R9 single miss");
    run_case(24'h050000, 8'd255, 8'd255, 24'h060000, "R9 full range");
  endtask

  task automatic t_oob();
    run_case(24'h00abcd, 8'd200, 8'd3, 24'h001000, "R5 far out");
  endtask

  task automatic t_wrap();
    run_case(24'hfffff0, 8'd6, 8'd10, 24'h000001, "R7 wrap call");
    run_case(24'hfffffe, 8'd9, 8'd4, 24'h000100, "R7 wrap fall");
  endtask

  initial begin
    t_reset();
    t_basic();
    t_bounds();
    t_oob();
    t_wrap();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5.0 * 100000);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule